// File: doc/BRIEF.md
# Card Bus Clock Divider and Gate

This block derives the serial clock for a memory-card bus from the block clock. It does not toggle a real clock net. It produces two single-cycle strobes in the block clock domain, one marking each rising edge and one marking each falling edge of the bus clock. It also produces a level copy of the bus clock. A three-bit rate code picks the half-period: `BASE_HALF` block cycles at code 0, doubled for each step of the code. With the block clock at twice the 19.5 MHz base rate and `BASE_HALF` = 1, code 0 gives 19.5 MHz and code 6 gives about 305 kHz.

Software drives the block through two strobes, one to start the clock and one to stop it. A start loads the rate code and begins clocking. A stop does not cut the clock at once. The clock finishes its current period, spends one full low half, and only then halts. At that point the enabled status drops and a one-cycle event reports that the clock is off. The rate code is used only when a start is accepted, so changing it while the clock runs has no effect.

A command request can ask for the card wake-up preamble. The block then counts a fixed run of complete bus clocks, 80 by default, before it issues the command-start pulse. A request without that flag issues the pulse on the next cycle.

Top module: `mmc_busclk_ctrl`

## Requirements
- R1: After reset, `clk_on`, `bus_lvl`, `rise_en`, `fall_en`, `clk_off_evt`, `cmd_start` and `pre_busy` are all 0.
- R2: With rate code 0, consecutive `rise_en` pulses are `2*BASE_HALF` block cycles apart.
- R3: With rate code c (1 to 6), consecutive `rise_en` pulses are `2*(BASE_HALF<<c)` block cycles apart.
- R4: A start strobe that arrives with rate code 7 is ignored: `clk_on` stays 0 and no edge strobe appears.
- R5: A start strobe accepted while the clock is off sets `clk_on` and produces a `rise_en` pulse in the next cycle.
- R6: After a stop strobe while running, no further `rise_en` occurs. `clk_on` stays 1 until the bus clock has completed a full low half after its last fall. `clk_off_evt` is high for exactly one cycle, `BASE_HALF<<code` + 1 cycles after the last `fall_en`, in the same cycle that `clk_on` first reads 0 with `bus_lvl` low.
- R7: A stop strobe while the clock is off produces no `clk_off_evt`, and `clk_on` stays 0.
- R8: Changes to the rate code, and start strobes, while the clock runs do not alter the running period.
- R9: `rise_en` and `fall_en` are never high together, they strictly alternate starting with a rise, and they occur only while `clk_on` is 1.
- R10: A command request with the preamble flag clear pulses `cmd_start` for one cycle, in the cycle after the request.
- R11: A command request with the preamble flag set raises `pre_busy`. It then pulses `cmd_start` in the cycle after the 80th `fall_en` that follows the request, and `pre_busy` stays high until that point.
- R12: A command request that arrives while `pre_busy` is high is ignored and produces no additional `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (twice the base bus rate by default) |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_code | input | 3 | Divider selection; valid 0..6 |
| start_req | input | 1 | Strobe: start clocking at the current rate code |
| stop_req | input | 1 | Strobe: halt the clock at the next safe point |
| cmd_req | input | 1 | Strobe: a command wants to begin |
| cmd_init | input | 1 | With `cmd_req`: send the wake-up preamble first |
| clk_on | output | 1 | Clock-enabled status |
| clk_off_evt | output | 1 | One-cycle pulse when the clock has actually halted |
| bus_lvl | output | 1 | Level of the bus clock |
| rise_en | output | 1 | One-cycle strobe at each bus clock rising edge |
| fall_en | output | 1 | One-cycle strobe at each bus clock falling edge |
| cmd_start | output | 1 | One-cycle pulse: the command may start |
| pre_busy | output | 1 | High while the preamble clocks are being counted |

## Verification
The properties assume that reset is asserted for at least one clock before any strobe is given. They also assume that all inputs are synchronous to `clk`. They place no restriction on when stop, start or command strobes arrive, because each such strobe is legal in every state. The directed stimulus pulses each strobe for one cycle on the falling clock edge. It sends a stop only after at least one bus-clock fall has happened, so that the measured halt distance always has a reference edge.

// File: rtl/mmc_busclk_pkg.sv
package mmc_busclk_pkg;

   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } busclk_phase_e;

   // Terminal count of the half-period counter for a given code.
   function automatic int unsigned half_term(input int unsigned base_half,
                                             input int unsigned code);
      return (base_half << code) - 1;
   endfunction

endpackage

// File: rtl/mmc_busclk_rate_map.sv
module mmc_busclk_rate_map #(
   parameter int unsigned RATE_W    = 3,
   parameter int unsigned NUM_RATES = 7,
   parameter int unsigned BASE_HALF = 1,
   parameter int unsigned CNT_W     = 8,
   parameter bit          USE_TABLE = 1'b0
) (
   input  logic [RATE_W-1:0] rate_code,
   output logic              rate_ok,
   output logic [CNT_W-1:0]  term
);
   import mmc_busclk_pkg::*;

   assign rate_ok = (int'(rate_code) < NUM_RATES);

   if (USE_TABLE) begin : g_table
      logic [CNT_W-1:0] term_tab [NUM_RATES];
      for (genvar i = 0; i < NUM_RATES; i++) begin : g_ent
         assign term_tab[i] = CNT_W'(half_term(BASE_HALF, i));
      end
      always_comb begin
         term = '0;
         for (int k = 0; k < NUM_RATES; k++) begin
            if (int'(rate_code) == k) term = term_tab[k];
         end
      end
   end else begin : g_shift
      logic [CNT_W-1:0] base_v;
      assign base_v = CNT_W'(BASE_HALF);
      always_comb begin
         term = '0;
         if (rate_ok) term = (base_v << rate_code) - CNT_W'(1);
      end
   end

endmodule

// File: rtl/mmc_busclk_sequencer.sv
module mmc_busclk_sequencer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             rate_ok,
   input  logic [CNT_W-1:0] term_in,
   output logic             clk_on,
   output logic             bus_lvl,
   output logic             rise_en,
   output logic             fall_en,
   output logic             off_evt
);
   import mmc_busclk_pkg::*;

   busclk_phase_e    ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term_q;
   logic             stop_pend_q;
   logic             evt_q;
   logic             running;
   logic             tick;

   assign running = (ph_q != PH_OFF);
   assign tick    = running && (cnt_q == term_q);
   assign rise_en = tick && (ph_q == PH_LOW) && !stop_pend_q;
   assign fall_en = tick && (ph_q == PH_HIGH);
   assign clk_on  = running;
   assign bus_lvl = (ph_q == PH_HIGH);
   assign off_evt = evt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q        <= PH_OFF;
         cnt_q       <= '0;
         term_q      <= '0;
         stop_pend_q <= 1'b0;
         evt_q       <= 1'b0;
      end else begin
         evt_q <= 1'b0;
         unique case (ph_q)
            PH_OFF: begin
               if (start_req && rate_ok) begin
                  ph_q        <= PH_LOW;
                  term_q      <= term_in;
                  cnt_q       <= term_in;
                  stop_pend_q <= 1'b0;
               end
            end
            PH_LOW: begin
               if (stop_req) stop_pend_q <= 1'b1;
               if (tick) begin
                  cnt_q <= '0;
                  if (stop_pend_q) begin
                     ph_q        <= PH_OFF;
                     stop_pend_q <= 1'b0;
                     evt_q       <= 1'b1;
                  end else begin
                     ph_q <= PH_HIGH;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            PH_HIGH: begin
               if (stop_req) stop_pend_q <= 1'b1;
               if (tick) begin
                  cnt_q <= '0;
                  ph_q  <= PH_LOW;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: begin
               ph_q <= PH_OFF;
            end
         endcase
      end
   end

endmodule

// File: rtl/mmc_busclk_preamble.sv
module mmc_busclk_preamble #(
   parameter int unsigned PRE_CLOCKS = 80,
   parameter int unsigned PRE_W      = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_req,
   input  logic cmd_init,
   input  logic fall_en,
   output logic cmd_start,
   output logic pre_busy
);
   logic [PRE_W-1:0] left_q;
   logic             go_q;

   assign pre_busy  = (left_q != '0);
   assign cmd_start = go_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         go_q   <= 1'b0;
      end else begin
         go_q <= 1'b0;
         if (pre_busy) begin
            if (fall_en) begin
               left_q <= left_q - PRE_W'(1);
               if (left_q == PRE_W'(1)) go_q <= 1'b1;
            end
         end else if (cmd_req) begin
            if (cmd_init) left_q <= PRE_W'(PRE_CLOCKS);
            else          go_q   <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/mmc_busclk_ctrl.sv
module mmc_busclk_ctrl #(
   parameter int unsigned RATE_W     = 3,
   parameter int unsigned NUM_RATES  = 7,
   parameter int unsigned BASE_HALF  = 1,
   parameter int unsigned PRE_CLOCKS = 80,
   parameter bit          USE_TABLE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_code,
   input  logic              start_req,
   input  logic              stop_req,
   input  logic              cmd_req,
   input  logic              cmd_init,
   output logic              clk_on,
   output logic              clk_off_evt,
   output logic              bus_lvl,
   output logic              rise_en,
   output logic              fall_en,
   output logic              cmd_start,
   output logic              pre_busy
);
   localparam int unsigned MAX_HALF = BASE_HALF << (NUM_RATES - 1);
   localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1) + 1;
   localparam int unsigned PRE_W    = $clog2(PRE_CLOCKS + 1);

   if (NUM_RATES < 1 || NUM_RATES > (1 << RATE_W)) begin : g_bad_rates
      $error("NUM_RATES must fit the rate code width");
   end
   if (BASE_HALF < 1) begin : g_bad_half
      $error("BASE_HALF must be at least one cycle");
   end
   if (PRE_CLOCKS < 1) begin : g_bad_pre
      $error("PRE_CLOCKS must be at least one");
   end

   logic             rate_ok;
   logic [CNT_W-1:0] term;

   mmc_busclk_rate_map #(
      .RATE_W   (RATE_W),
      .NUM_RATES(NUM_RATES),
      .BASE_HALF(BASE_HALF),
      .CNT_W    (CNT_W),
      .USE_TABLE(USE_TABLE)
   ) u_rate (
      .rate_code(rate_code),
      .rate_ok  (rate_ok),
      .term     (term)
   );

   mmc_busclk_sequencer #(
      .CNT_W(CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_req(start_req),
      .stop_req (stop_req),
      .rate_ok  (rate_ok),
      .term_in  (term),
      .clk_on   (clk_on),
      .bus_lvl  (bus_lvl),
      .rise_en  (rise_en),
      .fall_en  (fall_en),
      .off_evt  (clk_off_evt)
   );

   mmc_busclk_preamble #(
      .PRE_CLOCKS(PRE_CLOCKS),
      .PRE_W     (PRE_W)
   ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_req  (cmd_req),
      .cmd_init (cmd_init),
      .fall_en  (fall_en),
      .cmd_start(cmd_start),
      .pre_busy (pre_busy)
   );

endmodule

// File: rtl/mmc_busclk_ctrl_chk.sv
module mmc_busclk_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic stop_req,
   input logic clk_on,
   input logic clk_off_evt,
   input logic bus_lvl,
   input logic rise_en,
   input logic fall_en,
   input logic cmd_start,
   input logic pre_busy
);

   AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_en && fall_en)); // R9

   AST_EDGES_NEED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_en || fall_en) |-> clk_on); // R9

   AST_RISE_GOES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      rise_en |=> bus_lvl); // R9

   AST_FALL_GOES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fall_en |=> !bus_lvl); // R9

   AST_OFF_EVT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      clk_off_evt |-> (!clk_on && $past(clk_on))); // R6

   AST_HALT_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_on) |-> ($past(!bus_lvl) && clk_off_evt)); // R6

   AST_IDLE_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_on && stop_req) |=> !clk_off_evt); // R7

   AST_CMD_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> !pre_busy); // R11

   AST_PRE_WAITS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_busy && !fall_en) |=> pre_busy); // R11

endmodule

bind mmc_busclk_ctrl mmc_busclk_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_req   (stop_req),
   .clk_on     (clk_on),
   .clk_off_evt(clk_off_evt),
   .bus_lvl    (bus_lvl),
   .rise_en    (rise_en),
   .fall_en    (fall_en),
   .cmd_start  (cmd_start),
   .pre_busy   (pre_busy)
);

// File: tb/mmc_busclk_ctrl_tb.sv
module mmc_busclk_ctrl_tb;
   localparam int HALF0 = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] rate_code = 3'd0;
   logic       start_req = 1'b0;
   logic       stop_req = 1'b0;
   logic       cmd_req = 1'b0;
   logic       cmd_init = 1'b0;
   logic       clk_on, clk_off_evt, bus_lvl, rise_en, fall_en, cmd_start, pre_busy;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   mmc_busclk_ctrl #(.BASE_HALF(HALF0)) u_dut (
      .clk(clk), .rst_n(rst_n), .rate_code(rate_code),
      .start_req(start_req), .stop_req(stop_req),
      .cmd_req(cmd_req), .cmd_init(cmd_init),
      .clk_on(clk_on), .clk_off_evt(clk_off_evt), .bus_lvl(bus_lvl),
      .rise_en(rise_en), .fall_en(fall_en),
      .cmd_start(cmd_start), .pre_busy(pre_busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wait_rise(output int n);
      n = 0;
      do begin
         step();
         n++;
      end while (!rise_en && n < 1000);
   endtask

   task automatic start_clk(input int code);
      rate_code = 3'(code);
      start_req = 1'b1;
      step();
      start_req = 1'b0;
   endtask

   // Called in a cycle where rise_en is high; checks R6 on the way down.
   task automatic stop_clk(input int code);
      int i;
      int rises;
      int lastf;
      int on_bad;
      bit got;
      i = 0; rises = 0; lastf = -1000; on_bad = 0; got = 1'b0;
      stop_req = 1'b1;
      step();
      stop_req = 1'b0;
      i = 1;
      while (i < 1000) begin
         if (rise_en) rises++;
         if (fall_en) lastf = i;
         if (clk_off_evt) begin
            got = 1'b1;
            break;
         end
         if (!clk_on) on_bad++;
         step();
         i++;
      end
      check(got, "R6 off event seen", int'(got), 1);
      check(rises == 0, "R6 no rise after stop", rises, 0);
      check(on_bad == 0, "R6 clk_on held until halt", on_bad, 0);
      check(!clk_on && !bus_lvl, "R6 halted low", int'(clk_on), 0);
      check(i - lastf == (HALF0 << code) + 1, "R6 full low half before halt",
            i - lastf, (HALF0 << code) + 1);
      step();
      check(!clk_off_evt, "R6 event one cycle", int'(clk_off_evt), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      check({clk_on, bus_lvl, rise_en, fall_en, clk_off_evt, cmd_start, pre_busy} == 7'b0,
            "R1 reset state",
            int'({clk_on, bus_lvl, rise_en, fall_en, clk_off_evt, cmd_start, pre_busy}), 0);
   endtask

   task automatic t_rate_sweep();
      int n;
      for (int c = 0; c < 7; c++) begin
         start_clk(c);
         check(clk_on, "R5 clk_on after start", int'(clk_on), 1);
         check(rise_en, "R5 first rise next cycle", int'(rise_en), 1);
         wait_rise(n);
         if (c == 0) check(n == 2 * HALF0, "R2 base period", n, 2 * HALF0);
         else        check(n == 2 * (HALF0 << c), "R3 divided period", n, 2 * (HALF0 << c));
         stop_clk(c);
      end
   endtask

   task automatic t_bad_rate();
      int seen;
      seen = 0;
      rate_code = 3'd7;
      start_req = 1'b1;
      step();
      start_req = 1'b0;
      for (int k = 0; k < 6; k++) begin
         if (clk_on || rise_en) seen++;
         step();
      end
      check(seen == 0, "R4 code 7 refused", seen, 0);
   endtask

   task automatic t_idle_stop();
      int seen;
      seen = 0;
      stop_req = 1'b1;
      step();
      stop_req = 1'b0;
      for (int k = 0; k < 5; k++) begin
         if (clk_off_evt || clk_on) seen++;
         step();
      end
      check(seen == 0, "R7 idle stop silent", seen, 0);
   endtask

   task automatic t_rate_frozen();
      int n;
      start_clk(2);
      rate_code = 3'd0;
      start_req = 1'b1;
      wait_rise(n);
      start_req = 1'b0;
      check(n == 2 * (HALF0 << 2), "R8 period frozen", n, 2 * (HALF0 << 2));
      wait_rise(n);
      check(n == 2 * (HALF0 << 2), "R8 period still frozen", n, 2 * (HALF0 << 2));
      stop_clk(2);
   endtask

   task automatic t_alternate();
      int bad;
      bit expect_rise;
      int n;
      bad = 0;
      expect_rise = 1'b1;
      start_clk(1);
      for (int k = 0; k < 60; k++) begin
         if (rise_en && fall_en) bad++;
         if (rise_en) begin
            if (!expect_rise) bad++;
            expect_rise = 1'b0;
         end
         if (fall_en) begin
            if (expect_rise) bad++;
            expect_rise = 1'b1;
         end
         step();
      end
      check(bad == 0, "R9 edges alternate", bad, 0);
      wait_rise(n);
      stop_clk(1);
   endtask

   task automatic t_cmd_plain();
      cmd_req  = 1'b1;
      cmd_init = 1'b0;
      step();
      cmd_req = 1'b0;
      check(cmd_start, "R10 start next cycle", int'(cmd_start), 1);
      step();
      check(!cmd_start, "R10 start one cycle", int'(cmd_start), 0);
   endtask

   task automatic t_preamble();
      int falls;
      int busy_bad;
      int extra;
      int k;
      int n;
      falls = 0; busy_bad = 0; extra = 0; k = 0;
      start_clk(1);
      cmd_req  = 1'b1;
      cmd_init = 1'b1;
      step();
      cmd_req  = 1'b0;
      cmd_init = 1'b0;
      while (!cmd_start && k < 2000) begin
         if (!pre_busy) busy_bad++;
         if (fall_en) falls++;
         k++;
         cmd_req  = (k == 20);
         cmd_init = (k == 20);
         step();
      end
      cmd_req  = 1'b0;
      cmd_init = 1'b0;
      check(cmd_start, "R11 command start seen", int'(cmd_start), 1);
      check(falls == 80, "R11 preamble length", falls, 80);
      check(busy_bad == 0, "R11 busy during preamble", busy_bad, 0);
      for (int j = 0; j < 400; j++) begin
         step();
         if (cmd_start || pre_busy) extra++;
      end
      check(extra == 0, "R12 request during preamble ignored", extra, 0);
      wait_rise(n);
      stop_clk(1);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      t_reset();
      t_rate_sweep();
      t_bad_rate();
      t_idle_stop();
      t_rate_frozen();
      t_alternate();
      t_cmd_plain();
      t_preamble();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule